// File: doc/BRIEF.md
# BCD Real-Time Clock Core with Square-Wave Output

This core keeps calendar time in packed-BCD bytes and advances it once per second. The second is derived by counting pulses on `tick_32k`, a single-cycle enable that pulses at 32.768 kHz in the real system. Seconds, minutes, hours, weekday, date, month and year live at byte addresses 0x00 through 0x06. The control byte sits at 0x07. The rest of the address space up to 0x3F is plain scratch storage. The hours byte can count either in 24-hour form or in 12-hour form with a morning/afternoon flag. A halt bit in the seconds byte freezes the time. One output pin carries either a square wave at a selectable rate or a static level.

A bus slave reaches every byte through a request/response port. The request side is valid/ready: a request is taken in a cycle where `req_valid` and `req_ready` are both high. A write takes effect at that clock edge. A read places its data on the response side one cycle later. The response side is also valid/ready. `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is seen high, and `req_ready` stays low while an unaccepted response is pending. This is the only back-pressure the block applies.

Parameter `DIV_W` sets the pulses per second to 2^DIV_W. The default is 15, which gives 32768 pulses per second. `DIV_W` must be at least 3.

Top module: `rtc_core`

## Requirements
- R1: After reset, reads return 0x00 for seconds, minutes, hours, year and control, and 0x01 for weekday, date and month. Unused bits read back as 0. The writable bit masks are:
  - 0x00: 0xFF
  - 0x01: 0x7F
  - 0x02: 0x7F
  - 0x03: 0x07
  - 0x04: 0x3F
  - 0x05: 0x1F
  - 0x06: 0xFF
  - 0x07: 0x93
- R2: A request is accepted when `req_valid` and `req_ready` are both high. Read data appears with `rsp_valid` one cycle after acceptance and holds until `rsp_ready` is high. `req_ready` is low while a response waits.
- R3: Seconds advance once every 2^DIV_W `tick_32k` pulses. A write to address 0x00 restarts the sub-second count, so the first advance comes exactly 2^DIV_W pulses after that write.
- R4: Seconds and minutes count BCD 00..59. A roll from 59 to 00 carries into the next field.
- R5: While bit 7 of address 0x00 is 1, no time or date field advances. Clearing it resumes counting.
- R6: With hours bit 6 = 0 (24-hour), hours count BCD 00..23. The step from 23 to 00 advances weekday and date.
- R7: With hours bit 6 = 1 (12-hour), bits 4:0 count BCD 12,01..11 and bit 5 is the PM flag (1 = PM). The step from 11 to 12 toggles PM. The step from 11 PM to 12 AM advances weekday and date.
- R8: Weekday counts 1..7 and wraps from 7 to 1.
- R9: Date wraps to 01 after:
  - 28 in month 02;
  - 30 in months 04, 06, 09 and 11;
  - 31 in every other month.
  A date wrap advances the month. Month wraps 12 to 01 and advances the year. Year wraps 99 to 00.
- R10: When control bit 4 (square-wave enable) is 0, `sqw_out` equals control bit 7.
- R11: When control bit 4 is 1, control bits 1:0 pick the rate:
  - 00: one cycle per 2^DIV_W pulses;
  - 01: one cycle per 8 pulses;
  - 10: one cycle per 4 pulses;
  - 11: `sqw_out` follows `tick_32k` itself.
- R12: Addresses 0x08 to 0x3F store and return any byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | Sub-second enable pulse |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken |
| rsp_data | output | 8 | Read data |
| sqw_out | output | 1 | Square wave or static level |

## Verification
The bench goes after the rollover corners:
- 59 seconds and 59 minutes into the hour.
- 23 into 00.
- 11 AM into 12 PM, and 11 PM into 12 AM. A design that toggled the flag on the wrong step would show AM noon or a missing date advance.
- The end of February, April, January and December together with year 99. A design with wrong month lengths would show date 29 or 31 in the wrong month.

It checks that a halted clock keeps the same seconds over many pulses. It checks that the advance comes on pulse 2^DIV_W after a seconds write and not one pulse early. This catches a divider that is not restarted. It counts square-wave edges for each rate to catch a wrong counter tap. It holds back `rsp_ready` to catch a response that is dropped or changes while stalled.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NUM_TIME = 7;
  localparam int unsigned CTL_OUT  = 7;
  localparam int unsigned CTL_SQWE = 4;
  localparam logic [7:0]  CTL_MASK = 8'h93;

  // add one to a packed-BCD byte
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // last date of a BCD month, February fixed at 28
  function automatic logic [7:0] month_last(input logic [7:0] m);
    case (m)
      8'h02:                      return 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int unsigned DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       clr,
  input  logic [1:0] rate,
  input  logic       sq_en,
  input  logic       out_lvl,
  output logic       sec_tick,
  output logic       sqw
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (tick_in) cnt <= cnt + 1'b1;
  end

  assign sec_tick = tick_in && !clr && (cnt == '1);

  always_comb begin
    if (!sq_en) sqw = out_lvl;
    else begin
      case (rate)
        2'b00:   sqw = cnt[DIV_W-1];
        2'b01:   sqw = cnt[2];
        2'b10:   sqw = cnt[1];
        default: sqw = tick_in;
      endcase
    end
  end

  // R3
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !sec_tick);
  // R3
  tick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> tick_in);
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sec_tick,
  input  logic                     wr_en,
  input  logic [2:0]               wr_idx,
  input  logic [7:0]               wr_data,
  output logic [NUM_TIME-1:0][7:0] time_o
);
  logic [7:0] sec_q, min_q, hr_q, day_q, date_q, mon_q, yr_q;
  logic [7:0] hr_n, last_d;
  logic       run, s_wrap, m_wrap, carry_h, d_carry, day_go;

  always_comb begin
    run     = sec_tick && !sec_q[7];
    s_wrap  = (sec_q[6:0] == 7'h59);
    m_wrap  = (min_q == 8'h59);
    carry_h = run && s_wrap && m_wrap;
    d_carry = 1'b0;
    if (hr_q[6]) begin
      if (hr_q[4:0] == 5'h12) hr_n = (hr_q & 8'h60) | 8'h01;
      else if (hr_q[4:0] == 5'h11) begin
        hr_n    = ((hr_q & 8'h60) ^ 8'h20) | 8'h12;
        d_carry = hr_q[5];
      end else hr_n = (hr_q & 8'h60) | bcd_inc(hr_q & 8'h1F);
    end else if (hr_q[5:0] == 6'h23) begin
      hr_n    = 8'h00;
      d_carry = 1'b1;
    end else hr_n = bcd_inc(hr_q & 8'h3F);
    day_go = carry_h && d_carry;
    last_d = month_last(mon_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00; day_q <= 8'h01;
      date_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00;
    end else begin
      if (run) begin
        sec_q <= s_wrap ? 8'h00 : bcd_inc(sec_q);
        if (s_wrap) min_q <= m_wrap ? 8'h00 : bcd_inc(min_q);
        if (carry_h) hr_q <= hr_n;
        if (day_go) begin
          day_q <= (day_q == 8'h07) ? 8'h01 : day_q + 8'h01;
          if (date_q == last_d) begin
            date_q <= 8'h01;
            mon_q  <= (mon_q == 8'h12) ? 8'h01 : bcd_inc(mon_q);
            if (mon_q == 8'h12) yr_q <= (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
          end else date_q <= bcd_inc(date_q);
        end
      end
      if (wr_en) begin
        case (wr_idx)
          3'd0: sec_q  <= wr_data;
          3'd1: min_q  <= wr_data & 8'h7F;
          3'd2: hr_q   <= wr_data & 8'h7F;
          3'd3: day_q  <= wr_data & 8'h07;
          3'd4: date_q <= wr_data & 8'h3F;
          3'd5: mon_q  <= wr_data & 8'h1F;
          3'd6: yr_q   <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign time_o = {yr_q, mon_q, date_q, day_q, hr_q, min_q, sec_q};

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[7] && !wr_en) |=> $stable(time_o));
  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && s_wrap && !wr_en) |=> (sec_q == 8'h00) && (min_q != $past(min_q)));
  // R7
  noon_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_h && hr_q == 8'h51 && !wr_en) |=> hr_q == 8'h72);
  // R6
  midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_h && hr_q == 8'h23 && !wr_en) |=> (hr_q == 8'h00) && (date_q != $past(date_q)));
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_W  = 15,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              sqw_out
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned RAM_N = DEPTH - 8;

  logic [NUM_TIME-1:0][7:0] tm;
  logic [7:0] ctrl_q, rd_val;
  logic [7:0] ram [RAM_N];
  logic accept, wr, rd, is_time, is_ctrl, sec_tick;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr        = accept && req_write;
  assign rd        = accept && !req_write;
  assign is_time   = req_addr < ADDR_W'(NUM_TIME);
  assign is_ctrl   = req_addr == ADDR_W'(NUM_TIME);

  rtc_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_32k),
    .clr(wr && req_addr == '0),
    .rate(ctrl_q[1:0]), .sq_en(ctrl_q[CTL_SQWE]), .out_lvl(ctrl_q[CTL_OUT]),
    .sec_tick(sec_tick), .sqw(sqw_out)
  );

  rtc_timekeeper u_tk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .wr_en(wr && is_time), .wr_idx(req_addr[2:0]), .wr_data(req_wdata),
    .time_o(tm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= 8'h00;
    else if (wr && is_ctrl) ctrl_q <= req_wdata & CTL_MASK;
  end

  always_ff @(posedge clk) begin
    if (wr && !is_time && !is_ctrl) ram[req_addr - ADDR_W'(8)] <= req_wdata;
  end

  always_comb begin
    if (is_time)      rd_val = tm[req_addr[2:0]];
    else if (is_ctrl) rd_val = ctrl_q;
    else              rd_val = ram[req_addr - ADDR_W'(8)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_val;
    end else if (rsp_ready) rsp_valid <= 1'b0;
  end

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));
  // R10
  static_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CTL_SQWE] |-> sqw_out == ctrl_q[CTL_OUT]);
endmodule

// File: tb/rtc_core_test.sv
`timescale 1ns/1ps
module rtc_core_test;
  logic clk = 0, rst_n = 0, tick = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [5:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic req_ready, rsp_valid, sqw;
  logic [7:0] rsp_data;
  int checks = 0, errs = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  rtc_core #(.DIV_W(4), .ADDR_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sqw_out(sqw)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  endtask

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses are taken
  always begin
    @(negedge clk); #1;
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errs++;
        $display("FAIL R2: unexpected response %h expected none", rsp_data);
      end else chk(rsp_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bus_op(logic w, logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    bus_op(1'b1, a, d);
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_op(1'b0, a, 8'h00);
  endtask

  task automatic run_ticks(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic count_edges(int n, output int t);
    logic prev;
    @(negedge clk); tick = 1; #1; prev = sqw; t = 0;
    repeat (n) begin
      @(negedge clk); #1;
      if (sqw !== prev) t++;
      prev = sqw;
    end
    tick = 0;
  endtask

  // set fields then seconds last (restarts divider) and run one second
  task automatic step_from(logic [7:0] hr, logic [7:0] mi, logic [7:0] se);
    wr(6'h02, hr); wr(6'h01, mi); wr(6'h00, se);
    run_ticks(16);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk({7'd0, sqw}, 8'h00, "R10 reset level");
    rd(6'h00, 8'h00, "R1 sec reset");
    rd(6'h02, 8'h00, "R1 hour reset");
    rd(6'h03, 8'h01, "R1 day reset");
    rd(6'h04, 8'h01, "R1 date reset");
    rd(6'h05, 8'h01, "R1 month reset");
    rd(6'h07, 8'h00, "R1 ctrl reset");

    // R3 divider restart
    wr(6'h00, 8'h00); run_ticks(15); rd(6'h00, 8'h00, "R3 no early step");
    run_ticks(1); rd(6'h00, 8'h01, "R3 step");
    run_ticks(8); wr(6'h00, 8'h10); run_ticks(15);
    rd(6'h00, 8'h10, "R3 restart after write");
    run_ticks(1); rd(6'h00, 8'h11, "R3 step after restart");

    // R4 carry chain
    step_from(8'h09, 8'h59, 8'h59);
    rd(6'h00, 8'h00, "R4 sec wrap"); rd(6'h01, 8'h00, "R4 min wrap");
    rd(6'h02, 8'h10, "R4 hour carry");

    // R6 and R8
    wr(6'h03, 8'h07); wr(6'h04, 8'h15); wr(6'h05, 8'h01);
    step_from(8'h23, 8'h59, 8'h59);
    rd(6'h02, 8'h00, "R6 midnight"); rd(6'h03, 8'h01, "R8 weekday wrap");
    rd(6'h04, 8'h16, "R6 date step");

    // R7 twelve-hour
    step_from(8'h51, 8'h59, 8'h59); rd(6'h02, 8'h72, "R7 11AM to 12PM");
    wr(6'h01, 8'h59); wr(6'h00, 8'h59); run_ticks(16);
    rd(6'h02, 8'h61, "R7 12PM to 1PM");
    wr(6'h03, 8'h03); wr(6'h04, 8'h20);
    step_from(8'h71, 8'h59, 8'h59); rd(6'h02, 8'h52, "R7 11PM to 12AM");
    rd(6'h03, 8'h04, "R7 weekday carry"); rd(6'h04, 8'h21, "R7 date carry");

    // R9 month lengths
    wr(6'h05, 8'h02); wr(6'h04, 8'h28); step_from(8'h23, 8'h59, 8'h59);
    rd(6'h04, 8'h01, "R9 feb end date"); rd(6'h05, 8'h03, "R9 feb end month");
    wr(6'h05, 8'h04); wr(6'h04, 8'h30); step_from(8'h23, 8'h59, 8'h59);
    rd(6'h04, 8'h01, "R9 apr end date"); rd(6'h05, 8'h05, "R9 apr end month");
    wr(6'h05, 8'h01); wr(6'h04, 8'h30); step_from(8'h23, 8'h59, 8'h59);
    rd(6'h04, 8'h31, "R9 jan 31"); rd(6'h05, 8'h01, "R9 jan stays");
    wr(6'h06, 8'h99); wr(6'h05, 8'h12); wr(6'h04, 8'h31);
    step_from(8'h23, 8'h59, 8'h59);
    rd(6'h04, 8'h01, "R9 dec date"); rd(6'h05, 8'h01, "R9 dec month");
    rd(6'h06, 8'h00, "R9 year wrap");

    // R5 halt
    wr(6'h00, 8'hB0); run_ticks(40); rd(6'h00, 8'hB0, "R5 halted");
    wr(6'h00, 8'h30); run_ticks(16); rd(6'h00, 8'h31, "R5 resumed");

    // R1 masks, R12 storage
    wr(6'h03, 8'hFF); rd(6'h03, 8'h07, "R1 weekday mask");
    wr(6'h07, 8'hFF); rd(6'h07, 8'h93, "R1 ctrl mask");
    wr(6'h08, 8'hA5); wr(6'h3F, 8'h5A);
    rd(6'h08, 8'hA5, "R12 low scratch"); rd(6'h3F, 8'h5A, "R12 high scratch");

    // R10 static level
    wr(6'h07, 8'h80); #1 chk({7'd0, sqw}, 8'h01, "R10 level high");
    wr(6'h07, 8'h00); #1 chk({7'd0, sqw}, 8'h00, "R10 level low");

    // R11 rates
    wr(6'h07, 8'h10); count_edges(64, t); chk(8'(t), 8'd8, "R11 rate 00 edges");
    wr(6'h07, 8'h11); count_edges(64, t); chk(8'(t), 8'd16, "R11 rate 01 edges");
    wr(6'h07, 8'h12); count_edges(64, t); chk(8'(t), 8'd32, "R11 rate 10 edges");
    wr(6'h07, 8'h13);
    @(negedge clk); tick = 1; #1 chk({7'd0, sqw}, 8'h01, "R11 pass high");
    @(negedge clk); tick = 0; #1 chk({7'd0, sqw}, 8'h00, "R11 pass low");

    // R2 back-pressure
    @(negedge clk); rsp_ready = 0;
    rd(6'h08, 8'hA5, "R2 stalled read");
    #1 chk({7'd0, req_ready}, 8'h00, "R2 ready low while pending");
    repeat (3) @(negedge clk);
    #1 chk(rsp_valid ? rsp_data : 8'hXX, 8'hA5, "R2 data held");
    @(negedge clk); rsp_ready = 1;
    repeat (3) @(negedge clk);
    rd(6'h3F, 8'h5A, "R2 after release");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errs++;
      $display("FAIL R2: got %0d pending responses expected 0", exp_q.size());
    end
    summary();
  end
endmodule